// File: doc/BRIEF.md
# Complex Stream Gain Scaler

This block multiplies every complex sample of an incoming stream by one real gain and passes on the full-precision products. Each input beat packs a signed in-phase part in the upper half and a signed quadrature part in the lower half. Each output beat carries the two products at double the component width, packed the same way. Both streams use AXI-Stream valid/ready handshakes, and the end-of-packet marker rides along with its sample.

The gain is held in a register. A small write/read port reaches that register. The block samples the register in the same cycle that it accepts a sample, so a later gain write never changes a product that is already in flight. A two-stage pipeline lies between the streams. A stalled output freezes both stages, and the input then stops accepting samples once both stages are occupied.

A build parameter selects one of two multiply cores that give the same results. The direct core is a plain signed multiply. The lane core matches a multiplier that takes the real part low and the imaginary part high, and that returns each component sign-extended in its own wide padded lane. This core swaps the halves going in, then swaps them back and drops the padding going out.

Top module: `cplx_gain_scaler`

## Requirements
- R1: An input beat holds signed I in bits [31:16] and signed Q in bits [15:0]. The output beat holds I×gain as a signed 32-bit value in bits [63:32] and Q×gain in bits [31:0], with the gain taken as a signed 16-bit value.
- R2: Reset sets the gain to 1, so after reset each output component is the sign-extended input component. After reset, m_tvalid is low.
- R3: A write with cfg_waddr equal to 0 loads cfg_wdata into the gain. A read with cfg_raddr equal to 0 returns the current gain on cfg_rdata. A read at any other offset returns 0, and a write at any other offset has no effect.
- R4: Each sample uses the gain that is in force at the clock edge where the sample is accepted. A gain write at that same edge, or at any later edge, applies only to later samples.
- R5: A sample accepted at clock edge k, while the pipeline is empty and m_tready is high, shows on the output with m_tvalid high after edge k+1 and not before.
- R6: The tlast of each input sample comes out with that sample's product.
- R7: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values. s_tready goes low when two samples are held and the output is stalled. Samples are never lost or duplicated under backpressure.
- R8: The lane-swapped, padded multiply core gives the same output stream as the direct core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 32 | Input sample: I [31:16], Q [15:0] |
| s_tlast | input | 1 | Input end of packet |
| s_tvalid | input | 1 | Input valid |
| s_tready | output | 1 | Input ready |
| m_tdata | output | 64 | Output product: I [63:32], Q [31:0] |
| m_tlast | output | 1 | Output end of packet |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| cfg_we | input | 1 | Gain register write strobe |
| cfg_waddr | input | 4 | Write offset |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | 4 | Read offset |
| cfg_rdata | output | 16 | Read data, combinational |

## Verification
The bench builds two instances with the default 16-bit component and gain widths and 40-bit lanes: one with the direct core and one with the lane core. Both instances get the same stimulus and are checked against the same expected stream, which tests whether the lane core swaps and drops padding correctly. The 16-bit defaults let the bench hit the extreme operands, such as -32768 times -32768 and full negative gains, where a wrong sign extension or a mis-cut lane would show. A random output-ready pattern and gain writes in the middle of the stream exercise the stall and gain-capture rules.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

   // Multiply core variant selected at build time
   typedef enum logic {
      CORE_DIRECT = 1'b0,
      CORE_LANES  = 1'b1
   } cgs_core_e;

endpackage

// File: rtl/cgs_gain_reg.sv
module cgs_gain_reg #(
   parameter int GAIN_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int GAIN_INIT = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [GAIN_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [GAIN_W-1:0] rdata,
   output logic [GAIN_W-1:0] gain
);

   localparam logic [GAIN_W-1:0] INIT_V = GAIN_W'(GAIN_INIT);
   localparam logic [ADDR_W-1:0] GAIN_OFS = '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         gain <= INIT_V;
      end else if (we && (waddr == GAIN_OFS)) begin
         gain <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (raddr == GAIN_OFS) begin
         rdata = gain;
      end
   end

endmodule

// File: rtl/cgs_pipe_ctl.sv
module cgs_pipe_ctl #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              out_ready,
   output logic [STAGES-1:0] adv,
   output logic [STAGES-1:0] valid
);

   logic [STAGES:0] go;
   logic [STAGES:0] feed;

   assign go[STAGES] = out_ready;
   assign feed[0]    = in_valid;
   assign in_ready   = go[0];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      // A stage may take new data when empty or when its own content moves on
      assign go[k]     = !valid[k] || go[k+1];
      assign adv[k]    = go[k];
      assign feed[k+1] = valid[k];

      always_ff @(posedge clk) begin
         if (rst) begin
            valid[k] <= 1'b0;
         end else if (go[k]) begin
            valid[k] <= feed[k];
         end
      end
   end

endmodule

// File: rtl/cgs_mul_direct.sv
module cgs_mul_direct #(
   parameter int COMP_W = 16,
   parameter int GAIN_W = 16,
   localparam int PROD_W = COMP_W + GAIN_W
) (
   input  logic [COMP_W-1:0] re_i,
   input  logic [COMP_W-1:0] im_i,
   input  logic [GAIN_W-1:0] gain_i,
   output logic [PROD_W-1:0] re_o,
   output logic [PROD_W-1:0] im_o
);

   logic signed [PROD_W-1:0] re_x, im_x, g_x;

   assign re_x = PROD_W'($signed(re_i));
   assign im_x = PROD_W'($signed(im_i));
   assign g_x  = PROD_W'($signed(gain_i));

   assign re_o = re_x * g_x;
   assign im_o = im_x * g_x;

endmodule

// File: rtl/cgs_mul_lanes.sv
module cgs_mul_lanes #(
   parameter int COMP_W = 16,
   parameter int GAIN_W = 16,
   parameter int LANE_W = 40,
   localparam int PROD_W = COMP_W + GAIN_W,
   localparam int DOUT_W = 2 * LANE_W
) (
   input  logic [COMP_W-1:0] re_i,
   input  logic [COMP_W-1:0] im_i,
   input  logic [GAIN_W-1:0] gain_i,
   output logic [PROD_W-1:0] re_o,
   output logic [PROD_W-1:0] im_o
);

   // Core operand order: real part low, imaginary part high
   logic [2*COMP_W-1:0] b_word;
   logic [2*GAIN_W-1:0] a_word;
   logic [DOUT_W-1:0]   dout;
   logic signed [LANE_W-1:0] lane_re, lane_im, b_re, b_im, a_re;
   logic lane_unused_pad;

   assign b_word = {im_i, re_i};
   assign a_word = {{GAIN_W{1'b0}}, gain_i};

   assign b_re = LANE_W'($signed(b_word[COMP_W-1:0]));
   assign b_im = LANE_W'($signed(b_word[2*COMP_W-1:COMP_W]));
   assign a_re = LANE_W'($signed(a_word[GAIN_W-1:0]));

   // Each product sign-extended across its own padded lane
   assign lane_re = b_re * a_re;
   assign lane_im = b_im * a_re;
   assign dout    = {lane_im, lane_re};

   // Swap back and keep the low bits of each lane
   assign re_o = dout[PROD_W-1:0];
   assign im_o = dout[LANE_W+PROD_W-1:LANE_W];

   assign lane_unused_pad = ^{dout[DOUT_W-1:LANE_W+PROD_W], dout[LANE_W-1:PROD_W], a_word[2*GAIN_W-1:GAIN_W]};

endmodule

// File: rtl/cplx_gain_scaler.sv
module cplx_gain_scaler
   import cgs_pkg::*;
#(
   parameter int        COMP_W    = 16,
   parameter int        GAIN_W    = 16,
   parameter int        LANE_W    = 40,
   parameter int        ADDR_W    = 4,
   parameter int        GAIN_INIT = 1,
   parameter cgs_core_e CORE      = CORE_DIRECT,
   localparam int       IN_W      = 2 * COMP_W,
   localparam int       PROD_W    = COMP_W + GAIN_W,
   localparam int       OUT_W     = 2 * PROD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IN_W-1:0]   s_tdata,
   input  logic              s_tlast,
   input  logic              s_tvalid,
   output logic              s_tready,
   output logic [OUT_W-1:0]  m_tdata,
   output logic              m_tlast,
   output logic              m_tvalid,
   input  logic              m_tready,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_waddr,
   input  logic [GAIN_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] cfg_raddr,
   output logic [GAIN_W-1:0] cfg_rdata
);

   localparam int STAGES = 2;

   if (COMP_W < 2 || GAIN_W < 2) begin : g_bad_width
      $error("component and gain widths must be at least 2");
   end
   if (CORE == CORE_LANES && LANE_W <= PROD_W) begin : g_bad_lane
      $error("lane width must exceed the product width");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("address width must be at least 1");
   end

   logic [GAIN_W-1:0] gain;
   logic [STAGES-1:0] adv, valid;

   logic [COMP_W-1:0] st1_re, st1_im;
   logic [GAIN_W-1:0] st1_gain;
   logic              st1_last;
   logic [PROD_W-1:0] prod_re, prod_im;
   logic [PROD_W-1:0] out_re, out_im;
   logic              out_last;

   cgs_gain_reg #(
      .GAIN_W   (GAIN_W),
      .ADDR_W   (ADDR_W),
      .GAIN_INIT(GAIN_INIT)
   ) u_gain_reg (
      .clk  (clk),
      .rst  (rst),
      .we   (cfg_we),
      .waddr(cfg_waddr),
      .wdata(cfg_wdata),
      .raddr(cfg_raddr),
      .rdata(cfg_rdata),
      .gain (gain)
   );

   cgs_pipe_ctl #(
      .STAGES(STAGES)
   ) u_pipe_ctl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (s_tvalid),
      .in_ready (s_tready),
      .out_ready(m_tready),
      .adv      (adv),
      .valid    (valid)
   );

   // Stage 1: capture sample, gain and packet end together
   always_ff @(posedge clk) begin
      if (adv[0]) begin
         st1_re   <= s_tdata[IN_W-1:COMP_W];
         st1_im   <= s_tdata[COMP_W-1:0];
         st1_gain <= gain;
         st1_last <= s_tlast;
      end
   end

   if (CORE == CORE_LANES) begin : g_lanes
      cgs_mul_lanes #(
         .COMP_W(COMP_W),
         .GAIN_W(GAIN_W),
         .LANE_W(LANE_W)
      ) u_mul (
         .re_i  (st1_re),
         .im_i  (st1_im),
         .gain_i(st1_gain),
         .re_o  (prod_re),
         .im_o  (prod_im)
      );
   end else begin : g_direct
      cgs_mul_direct #(
         .COMP_W(COMP_W),
         .GAIN_W(GAIN_W)
      ) u_mul (
         .re_i  (st1_re),
         .im_i  (st1_im),
         .gain_i(st1_gain),
         .re_o  (prod_re),
         .im_o  (prod_im)
      );
   end

   // Stage 2: registered products
   always_ff @(posedge clk) begin
      if (adv[1]) begin
         out_re   <= prod_re;
         out_im   <= prod_im;
         out_last <= st1_last;
      end
   end

   assign m_tdata  = {out_re, out_im};
   assign m_tlast  = out_last;
   assign m_tvalid = valid[1];

endmodule

// File: rtl/cgs_checker.sv
module cgs_checker #(
   parameter int OUT_W  = 64,
   parameter int GAIN_W = 16,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              s_tvalid,
   input logic              s_tready,
   input logic [OUT_W-1:0]  m_tdata,
   input logic              m_tlast,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_waddr,
   input logic [GAIN_W-1:0] cfg_wdata,
   input logic [ADDR_W-1:0] cfg_raddr,
   input logic [GAIN_W-1:0] cfg_rdata
);

   logic [2:0] occ;
   logic       took, gave;

   assign took = s_tvalid && s_tready;
   assign gave = m_tvalid && m_tready;

   always_ff @(posedge clk) begin
      if (rst) begin
         occ <= '0;
      end else begin
         occ <= occ + {2'b0, took} - {2'b0, gave};
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))) // R7
      else $error("output changed during stall");

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
      occ <= 3'd2) // R7
      else $error("more samples held than stages");

   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
      m_tvalid |-> (occ != 3'd0)) // R7
      else $error("output valid with nothing accepted");

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (occ == 3'd2 && !m_tready) |-> !s_tready) // R7
      else $error("input ready while full and stalled");

   AST_GAIN_WRITE: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_waddr == '0) |=> (cfg_raddr != '0 || cfg_rdata == $past(cfg_wdata))) // R3
      else $error("gain write not visible on read");

endmodule

bind cplx_gain_scaler cgs_checker #(
   .OUT_W (OUT_W),
   .GAIN_W(GAIN_W),
   .ADDR_W(ADDR_W)
) u_cgs_checker (
   .clk      (clk),
   .rst      (rst),
   .s_tvalid (s_tvalid),
   .s_tready (s_tready),
   .m_tdata  (m_tdata),
   .m_tlast  (m_tlast),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .cfg_we   (cfg_we),
   .cfg_waddr(cfg_waddr),
   .cfg_wdata(cfg_wdata),
   .cfg_raddr(cfg_raddr),
   .cfg_rdata(cfg_rdata)
);

// File: tb/cplx_gain_scaler_bench.sv
module cplx_gain_scaler_bench;

   typedef struct {
      logic [63:0] data;
      logic        last;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] s_tdata = '0;
   logic        s_tlast = 1'b0;
   logic        s_tvalid = 1'b0;
   logic        m_tready = 1'b1;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_waddr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [3:0]  cfg_raddr = '0;

   logic        s_tready_a, s_tready_b;
   logic [63:0] m_tdata_a, m_tdata_b;
   logic        m_tlast_a, m_tlast_b, m_tvalid_a, m_tvalid_b;
   logic [15:0] cfg_rdata_a, cfg_rdata_b;

   int checks = 0;
   int errors = 0;
   int rdy_mode = 0;       // 0 always ready, 1 random, 2 held low
   bit done = 1'b0;
   logic [15:0] model_gain = 16'd1;
   string cur_tag = "R1";

   exp_t q_a[$];
   exp_t q_b[$];

   always #2 clk = ~clk;   // 250 MHz

   cplx_gain_scaler u_cplx_gain_scaler (
      .clk(clk), .rst(rst),
      .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready_a),
      .m_tdata(m_tdata_a), .m_tlast(m_tlast_a), .m_tvalid(m_tvalid_a), .m_tready(m_tready),
      .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata_a)
   );

   cplx_gain_scaler #(.CORE(cgs_pkg::CORE_LANES)) u_cplx_gain_scaler_lanes (
      .clk(clk), .rst(rst),
      .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready_b),
      .m_tdata(m_tdata_b), .m_tlast(m_tlast_b), .m_tvalid(m_tvalid_b), .m_tready(m_tready),
      .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata_b)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] product(input logic [31:0] s, input logic [15:0] g);
      int re, im, gg;
      re = $signed(s[31:16]);
      im = $signed(s[15:0]);
      gg = $signed(g);
      return {32'(re * gg), 32'(im * gg)};
   endfunction

   // Output ready pattern, changed just after each rising edge
   logic [15:0] lfsr = 16'hACE1;
   always begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
         0: m_tready = 1'b1;
         1: m_tready = lfsr[0] | lfsr[3];
         default: m_tready = 1'b0;
      endcase
   end

   // Monitor: pops the scoreboard on each transfer, checks stall hold
   logic        prev_stall = 1'b0;
   logic [63:0] prev_data = '0;
   logic        prev_last = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         if (prev_stall) begin
            check("R7 hold", {m_tvalid_a, m_tlast_a, m_tdata_a[61:0]},
                  {1'b1, prev_last, prev_data[61:0]});
         end
         prev_stall = m_tvalid_a && !m_tready;
         prev_data  = m_tdata_a;
         prev_last  = m_tlast_a;
         if (m_tvalid_a && m_tready) begin
            if (q_a.size() == 0) begin
               check("R7 no extra output", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = q_a.pop_front();
               check({e.tag, " direct"}, {m_tdata_a}, e.data);
               check("R6 last", {63'd0, m_tlast_a}, {63'd0, e.last});
            end
         end
         if (m_tvalid_b && m_tready) begin
            if (q_b.size() == 0) begin
               check("R8 no extra output", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = q_b.pop_front();
               check({e.tag, " R8 lanes"}, m_tdata_b, e.data);
               check("R8 R6 last", {63'd0, m_tlast_b}, {63'd0, e.last});
            end
         end
      end
   end

   // Driver: offer one sample, optionally with a gain write at the same edge
   task automatic send(input logic [31:0] d, input logic last, input bit wr, input logic [15:0] g);
      exp_t e;
      @(negedge clk);
      s_tdata  = d;
      s_tlast  = last;
      s_tvalid = 1'b1;
      #1;
      while (!s_tready_a) begin
         @(negedge clk);
         #1;
      end
      check("R8 ready match", {63'd0, s_tready_b}, 64'd1);
      if (wr) begin
         cfg_we = 1'b1; cfg_waddr = 4'd0; cfg_wdata = g;
      end
      e.data = product(d, model_gain);
      e.last = last;
      e.tag  = cur_tag;
      q_a.push_back(e);
      q_b.push_back(e);
      @(posedge clk);
      if (wr) model_gain = g;
      #1;
      s_tvalid = 1'b0;
      cfg_we   = 1'b0;
   endtask

   task automatic write_gain(input logic [3:0] a, input logic [15:0] g);
      @(negedge clk);
      cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = g;
      @(posedge clk);
      if (a == 4'd0) model_gain = g;
      #1;
      cfg_we = 1'b0;
   endtask

   task automatic drain();
      for (int n = 0; n < 2000 && (q_a.size() != 0 || q_b.size() != 0); n++) @(negedge clk);
      check("R7 all delivered", 64'(q_a.size() + q_b.size()), 64'd0);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R2 reset state
      check("R2 valid after reset", {63'd0, m_tvalid_a | m_tvalid_b}, 64'd0);
      check("R2 gain after reset", {48'd0, cfg_rdata_a}, 64'd1);

      // R2 unity gain, R1 packing with extremes
      cur_tag = "R2";
      send(32'h7FFF_8000, 1'b0, 1'b0, '0);
      send(32'h0001_FFFF, 1'b1, 1'b0, '0);
      drain();

      // R3 register port
      write_gain(4'd0, 16'hFFFD);
      @(negedge clk);
      check("R3 read gain", {48'd0, cfg_rdata_a}, 64'h0000_0000_0000_FFFD);
      write_gain(4'd3, 16'h1234);
      @(negedge clk);
      check("R3 other write ignored", {48'd0, cfg_rdata_a}, 64'h0000_0000_0000_FFFD);
      cfg_raddr = 4'd5;
      #1;
      check("R3 other read zero", {48'd0, cfg_rdata_a}, 64'd0);
      cfg_raddr = 4'd0;

      // R1 negative gain, R6 last patterns
      cur_tag = "R1";
      send(32'h1234_EDCC, 1'b1, 1'b0, '0);
      send(32'h8000_7FFF, 1'b0, 1'b0, '0);
      write_gain(4'd0, 16'h8000);
      send(32'h8000_8000, 1'b1, 1'b0, '0);
      drain();

      // R5 latency from an empty pipeline
      cur_tag = "R5";
      write_gain(4'd0, 16'd7);
      send(32'h0003_FFFE, 1'b0, 1'b0, '0);
      @(negedge clk);
      check("R5 not valid after accept edge", {63'd0, m_tvalid_a}, 64'd0);
      @(negedge clk);
      check("R5 valid after next edge", {63'd0, m_tvalid_a & m_tvalid_b}, 64'd1);
      drain();

      // R4 gain written at the accept edge applies to the next sample only
      cur_tag = "R4";
      send(32'h0100_FF00, 1'b0, 1'b1, 16'd3);
      send(32'h0100_FF00, 1'b1, 1'b1, 16'hFFFF);
      send(32'h0100_FF00, 1'b0, 1'b0, '0);
      drain();

      // R7 fill while stalled
      cur_tag = "R7";
      rdy_mode = 2;
      @(negedge clk);
      send(32'h0011_0022, 1'b0, 1'b0, '0);
      send(32'h0033_0044, 1'b1, 1'b0, '0);
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = 32'h0055_0066;
      #1;
      check("R7 ready low when full", {63'd0, s_tready_a | s_tready_b}, 64'd0);
      s_tvalid = 1'b0;
      repeat (3) @(negedge clk);
      rdy_mode = 0;
      drain();

      // R7 random backpressure with gain changes mid stream
      rdy_mode = 1;
      for (int n = 0; n < 60; n++) begin
         send($urandom, n[2], (n % 9) == 4, 16'($urandom));
      end
      rdy_mode = 0;
      drain();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule